// File: doc/BRIEF.md
# Parallel Sample Input Packing Unit

This block takes 32-bit words that a CPU or DMA writes into a per-channel input register. It turns them into 16-bit samples for a pair of downstream filter channels. Each channel delivers its samples on a valid/ready handshake. A sample is consumed on a cycle where both valid and ready are high.

A two-bit packing field per channel sets how a word is used:

- **Standard:** one sample, taken from the low half.
- **Interleaving:** two samples for the same channel, low half first.
- **Dual-channel:** only channel 0 may use it. The low half feeds channel 0 and the high half is forwarded into channel 1's register. Channel 1's sample is offered only after channel 0 has taken its own.

The block also handles the following:

- It checks the halves being written against the mode, and protects channel 1 whenever dual-channel operation is involved.
- It drops a write that lands while the register still holds samples, and raises an overrun flag.
- It silently discards writes to a disabled channel.
- Disabling a channel flushes whatever that channel holds.

Each channel is a small state machine:

- **ST_EMPTY:** holding nothing.
  - Goes to ST_ONE on a single-sample load.
  - Goes to ST_FIRST on an interleaved load.
  - Goes to ST_PEER_WAIT on a forwarded load.
- **ST_ONE:** offers its low half, then returns to ST_EMPTY on acceptance.
- **ST_FIRST:** offers the low half, then goes to ST_SECOND on acceptance.
- **ST_SECOND:** offers the high half, then returns to ST_EMPTY on acceptance.
- **ST_PEER_WAIT:** channel 1 only. It holds a forwarded half and moves to ST_ONE when channel 0 accepts its sample, or when channel 0 is disabled.

From any state, a low enable returns the channel to ST_EMPTY.

Top module: `pdi_pack_unit`

## Requirements
- R1: After reset no channel offers a sample and both overrun and write-error flags read 0.
- R2: In standard mode (code 2'b00), a write with strobe 2'b01 to an enabled, empty channel yields exactly one sample equal to data[15:0]. After that sample is accepted the channel is empty.
- R3: In interleaving mode (code 2'b01), one write with strobe 2'b11 yields two samples for that channel: data[15:0] first, then data[31:16]. The register counts as full until the second one is accepted.
- R4: In dual-channel mode (code 2'b10) on channel 0, a write with strobe 2'b11 yields data[15:0] on channel 0. When channel 1 is enabled, data[31:16] then appears on channel 1, and it is offered only after the channel 0 sample has been accepted.
- R5: A write to channel 1 while channel 1's mode is 2'b10, or while channel 0's mode is 2'b10, loads nothing and sets wr_err[1].
- R6: Standard mode accepts only strobe 2'b01, because the upper half is protected. Interleaving and dual-channel modes accept only 2'b11. Any other strobe loads nothing and sets that channel's wr_err bit.
- R7: A write to a disabled channel loads nothing and sets no flag. Deasserting a channel's enable discards every sample it holds, and the channel offers nothing from the next cycle.
- R8: A write to a channel that still holds samples is dropped and sets that channel's overrun bit. For channel 0 in dual-channel mode, a forwarded sample still pending in channel 1 also counts as held.
- R9: Overrun and write-error bits are sticky until the matching flag_clr bit is high at a clock edge. A set in the same cycle takes precedence over the clear.
- R10: The reserved mode code 2'b11 behaves exactly like standard mode.
- R11: While a channel offers a sample and ready is low, valid stays high and the data does not change.
- R12: The packing mode is read at the moment of the write. Write-check priority: a disabled channel ignores the write, then a protection or strobe error applies, then a full register causes overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ch_en | input | 2 | Per-channel enable; bit n enables channel n |
| mode_ch0 | input | 2 | Packing mode of channel 0 |
| mode_ch1 | input | 2 | Packing mode of channel 1 |
| wr_en | input | 1 | Write strobe for the input registers |
| wr_ch | input | 1 | Target channel of the write |
| wr_strb | input | 2 | Half-word strobes: bit0 low half, bit1 high half |
| wr_data | input | 32 | Written word |
| flag_clr | input | 2 | Per-channel clear of overrun and write-error flags |
| smp_ready | input | 2 | Filter ready, one bit per channel |
| smp_valid | output | 2 | Sample valid, one bit per channel |
| smp_data_ch0 | output | 16 | Sample for channel 0 |
| smp_data_ch1 | output | 16 | Sample for channel 1 |
| overrun | output | 2 | Sticky overrun flags |
| wr_err | output | 2 | Sticky write-error flags |

## Verification
The bench runs a reference model through every cycle, under directed cases and seeded random traffic. It targets the dual-channel ordering: a design that let channel 1 go at once would show the forwarded half before channel 0 was consumed. It also targets the busy test for channel 0, which must include channel 1's pending forward. A design that missed this would overwrite an unconsumed forward instead of raising overrun. Further targets are the channel 1 protection, the upper-half strobe check in standard mode, the reserved code, a disable arriving mid-pair or during the forward wait, and a flag clear coinciding with a new set. A wrong design would show up in each case as a stale or extra sample or a lost flag.

// File: rtl/pdi_pkg.sv
package pdi_pkg;

    typedef enum logic [1:0] {
        MD_STD  = 2'b00,
        MD_ILV  = 2'b01,
        MD_DUAL = 2'b10,
        MD_RSV  = 2'b11
    } pack_mode_e;

    typedef enum logic [2:0] {
        ST_EMPTY,
        ST_ONE,
        ST_FIRST,
        ST_SECOND,
        ST_PEER_WAIT
    } slot_state_e;

    // Strobe pattern a given mode accepts: both halves for the two-sample
    // modes, low half only otherwise (upper half protected).
    function automatic logic strb_ok(input logic [1:0] mode, input logic [1:0] strb);
        if (mode == MD_ILV || mode == MD_DUAL)
            return strb == 2'b11;
        else
            return strb == 2'b01;
    endfunction

endpackage

// File: rtl/pdi_slot.sv
module pdi_slot
    import pdi_pkg::*;
#(
    parameter int HW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          ld_one,
    input  logic          ld_two,
    input  logic          ld_wait,
    input  logic [2*HW-1:0] ld_word,
    input  logic          peer_go,
    input  logic          smp_ready,
    output logic          smp_valid,
    output logic [HW-1:0] smp_data,
    output logic          empty,
    output logic          accept
);

    localparam int WW = 2 * HW;

    slot_state_e       state_q, state_d;
    logic [WW-1:0]     word_q, word_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            word_q  <= '0;
        end else begin
            state_q <= state_d;
            word_q  <= word_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        word_d  = word_q;
        if (!en) begin
            state_d = ST_EMPTY;
        end else begin
            unique case (state_q)
                ST_EMPTY: begin
                    if (ld_one) begin
                        state_d = ST_ONE;
                        word_d  = ld_word;
                    end else if (ld_two) begin
                        state_d = ST_FIRST;
                        word_d  = ld_word;
                    end else if (ld_wait) begin
                        state_d = ST_PEER_WAIT;
                        word_d  = ld_word;
                    end
                end
                ST_ONE:       if (accept)  state_d = ST_EMPTY;
                ST_FIRST:     if (accept)  state_d = ST_SECOND;
                ST_SECOND:    if (accept)  state_d = ST_EMPTY;
                ST_PEER_WAIT: if (peer_go) state_d = ST_ONE;
                default:                   state_d = ST_EMPTY;
            endcase
        end
    end

    // outputs
    always_comb begin
        smp_valid = 1'b0;
        smp_data  = '0;
        unique case (state_q)
            ST_ONE, ST_FIRST: begin
                smp_valid = 1'b1;
                smp_data  = word_q[HW-1:0];
            end
            ST_SECOND: begin
                smp_valid = 1'b1;
                smp_data  = word_q[WW-1:HW];
            end
            default: begin
                smp_valid = 1'b0;
                smp_data  = '0;
            end
        endcase
    end

    assign accept = smp_valid && smp_ready;
    assign empty  = (state_q == ST_EMPTY);

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !smp_ready && en) |=> (smp_valid && $stable(smp_data))); // R11

    AST_FLUSH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !smp_valid); // R7

    AST_LOAD_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_one || ld_two || ld_wait) |-> empty); // R8

    AST_LOAD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ld_one, ld_two, ld_wait})); // R12

endmodule

// File: rtl/pdi_wr_ctrl.sv
module pdi_wr_ctrl
    import pdi_pkg::*;
#(
    parameter int HW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      ch_en,
    input  logic [1:0]      mode0,
    input  logic [1:0]      mode1,
    input  logic            wr_en,
    input  logic            wr_ch,
    input  logic [1:0]      wr_strb,
    input  logic [2*HW-1:0] wr_data,
    input  logic [1:0]      flag_clr,
    input  logic [1:0]      empty,
    output logic [1:0]      ld_one,
    output logic [1:0]      ld_two,
    output logic [1:0]      ld_wait,
    output logic [2*HW-1:0] ld_word0,
    output logic [2*HW-1:0] ld_word1,
    output logic [1:0]      overrun,
    output logic [1:0]      wr_err
);

    localparam int WW = 2 * HW;

    logic       dual0, busy0, busy1;
    logic [1:0] set_ovr, set_err;

    assign dual0 = (pack_mode_e'(mode0) == MD_DUAL);
    assign busy0 = !empty[0] || (dual0 && !empty[1]);
    assign busy1 = !empty[1];

    always_comb begin
        ld_one   = '0;
        ld_two   = '0;
        ld_wait  = '0;
        set_ovr  = '0;
        set_err  = '0;
        ld_word0 = wr_data;
        ld_word1 = wr_data;
        if (wr_en && !wr_ch && ch_en[0]) begin
            if (!strb_ok(mode0, wr_strb)) begin
                set_err[0] = 1'b1;
            end else if (busy0) begin
                set_ovr[0] = 1'b1;
            end else begin
                unique case (pack_mode_e'(mode0))
                    MD_ILV:  ld_two[0] = 1'b1;
                    MD_DUAL: begin
                        ld_one[0] = 1'b1;
                        if (ch_en[1]) begin
                            ld_wait[1] = 1'b1;
                            ld_word1   = {{HW{1'b0}}, wr_data[WW-1:HW]};
                        end
                    end
                    default: ld_one[0] = 1'b1;
                endcase
            end
        end else if (wr_en && wr_ch && ch_en[1]) begin
            if (dual0 || pack_mode_e'(mode1) == MD_DUAL || !strb_ok(mode1, wr_strb)) begin
                set_err[1] = 1'b1;
            end else if (busy1) begin
                set_ovr[1] = 1'b1;
            end else if (pack_mode_e'(mode1) == MD_ILV) begin
                ld_two[1] = 1'b1;
            end else begin
                ld_one[1] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            overrun <= '0;
            wr_err  <= '0;
        end else begin
            overrun <= (overrun & ~flag_clr) | set_ovr;
            wr_err  <= (wr_err  & ~flag_clr) | set_err;
        end
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_err[0] && !flag_clr[0]) |=> wr_err[0]); // R9

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun[1] && !flag_clr[1]) |=> overrun[1]); // R9

    AST_CH1_PROTECT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ch && ch_en[1] && (mode0 == 2'b10 || mode1 == 2'b10))
        |=> wr_err[1]); // R5

    AST_CH1_NO_LOAD_PROT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ch && (mode1 == 2'b10)) |-> !(ld_one[1] || ld_two[1])); // R5

endmodule

// File: rtl/pdi_pack_unit.sv
module pdi_pack_unit
    import pdi_pkg::*;
#(
    parameter int HW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      ch_en,
    input  logic [1:0]      mode_ch0,
    input  logic [1:0]      mode_ch1,
    input  logic            wr_en,
    input  logic            wr_ch,
    input  logic [1:0]      wr_strb,
    input  logic [2*HW-1:0] wr_data,
    input  logic [1:0]      flag_clr,
    input  logic [1:0]      smp_ready,
    output logic [1:0]      smp_valid,
    output logic [HW-1:0]   smp_data_ch0,
    output logic [HW-1:0]   smp_data_ch1,
    output logic [1:0]      overrun,
    output logic [1:0]      wr_err
);

    localparam int NCH = 2;
    localparam int WW  = 2 * HW;

    logic [NCH-1:0] ld_one, ld_two, ld_wait, empty, accept, peer_go;
    logic [WW-1:0]  ld_word0, ld_word1;
    logic [HW-1:0]  sdata [NCH];

    pdi_wr_ctrl #(.HW(HW)) u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ch_en    (ch_en),
        .mode0    (mode_ch0),
        .mode1    (mode_ch1),
        .wr_en    (wr_en),
        .wr_ch    (wr_ch),
        .wr_strb  (wr_strb),
        .wr_data  (wr_data),
        .flag_clr (flag_clr),
        .empty    (empty),
        .ld_one   (ld_one),
        .ld_two   (ld_two),
        .ld_wait  (ld_wait),
        .ld_word0 (ld_word0),
        .ld_word1 (ld_word1),
        .overrun  (overrun),
        .wr_err   (wr_err)
    );

    // channel 1 leaves the forward wait once channel 0 has taken its sample
    assign peer_go = {accept[0] | ~ch_en[0], 1'b0};

    for (genvar g = 0; g < NCH; g++) begin : g_slot
        pdi_slot #(.HW(HW)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (ch_en[g]),
            .ld_one    (ld_one[g]),
            .ld_two    (ld_two[g]),
            .ld_wait   (ld_wait[g]),
            .ld_word   ((g == 0) ? ld_word0 : ld_word1),
            .peer_go   (peer_go[g]),
            .smp_ready (smp_ready[g]),
            .smp_valid (smp_valid[g]),
            .smp_data  (sdata[g]),
            .empty     (empty[g]),
            .accept    (accept[g])
        );
    end

    assign smp_data_ch0 = sdata[0];
    assign smp_data_ch1 = sdata[1];

    AST_FWD_AFTER_CH0: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_wait[1] && ch_en[0]) |=> !smp_valid[1]); // R4

    AST_DUAL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_ch0 == 2'b10 && !empty[1]) |-> !ld_one[0] && !ld_two[0]); // R8

endmodule

// File: tb/pdi_pack_unit_test.sv
module pdi_pack_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  ch_en = '0, mode_ch0 = '0, mode_ch1 = '0;
    logic        wr_en = 1'b0, wr_ch = 1'b0;
    logic [1:0]  wr_strb = '0, flag_clr = '0, smp_ready = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  smp_valid, overrun, wr_err;
    logic [15:0] smp_data_ch0, smp_data_ch1;

    always #5 clk = ~clk;

    pdi_pack_unit uut (
        .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .mode_ch0(mode_ch0), .mode_ch1(mode_ch1),
        .wr_en(wr_en), .wr_ch(wr_ch), .wr_strb(wr_strb), .wr_data(wr_data),
        .flag_clr(flag_clr), .smp_ready(smp_ready), .smp_valid(smp_valid),
        .smp_data_ch0(smp_data_ch0), .smp_data_ch1(smp_data_ch1),
        .overrun(overrun), .wr_err(wr_err)
    );

    int n_chk = 0, n_bad = 0;
    string tag = "R1";

    // reference model
    logic [15:0] q0[$], q1[$];
    bit          w1 = 0;
    logic [1:0]  m_ovr = '0, m_err = '0;
    logic [1:0]  nx_en = '0, nx_m0 = '0, nx_m1 = '0;

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    function automatic bit sok(input logic [1:0] m, input logic [1:0] s);
        return (m == 2'b01 || m == 2'b10) ? (s == 2'b11) : (s == 2'b01);
    endfunction

    task automatic check_outputs();
        bit ev0, ev1;
        ev0 = q0.size() != 0;
        ev1 = (q1.size() != 0) && !w1;
        check("valid0", 32'(smp_valid[0]), 32'(ev0));
        if (ev0) check("data0", 32'(smp_data_ch0), 32'(q0[0]));
        check("valid1", 32'(smp_valid[1]), 32'(ev1));
        if (ev1) check("data1", 32'(smp_data_ch1), 32'(q1[0]));
        check("overrun", 32'(overrun), 32'(m_ovr));
        check("wr_err", 32'(wr_err), 32'(m_err));
    endtask

    task automatic model_step();
        bit v0, v1, a0, a1, b0, b1;
        logic [1:0] so, se;
        int l0, l1;
        v0 = q0.size() != 0;
        v1 = (q1.size() != 0) && !w1;
        a0 = v0 && smp_ready[0];
        a1 = v1 && smp_ready[1];
        b0 = (q0.size() != 0) || (mode_ch0 == 2'b10 && q1.size() != 0);
        b1 = q1.size() != 0;
        so = '0; se = '0; l0 = 0; l1 = 0;
        if (wr_en && !wr_ch && ch_en[0]) begin
            if (!sok(mode_ch0, wr_strb)) se[0] = 1'b1;
            else if (b0) so[0] = 1'b1;
            else if (mode_ch0 == 2'b01) l0 = 2;
            else begin
                l0 = 1;
                if (mode_ch0 == 2'b10 && ch_en[1]) l1 = 3;
            end
        end else if (wr_en && wr_ch && ch_en[1]) begin
            if (mode_ch1 == 2'b10 || mode_ch0 == 2'b10 || !sok(mode_ch1, wr_strb)) se[1] = 1'b1;
            else if (b1) so[1] = 1'b1;
            else l1 = (mode_ch1 == 2'b01) ? 2 : 1;
        end
        if (!ch_en[0]) q0.delete();
        else if (a0) void'(q0.pop_front());
        if (!ch_en[1]) begin
            q1.delete(); w1 = 0;
        end else if (w1) begin
            if (a0 || !ch_en[0]) w1 = 0;
        end else if (a1) void'(q1.pop_front());
        if (l0 >= 1) q0.push_back(wr_data[15:0]);
        if (l0 == 2) q0.push_back(wr_data[31:16]);
        if (l1 == 3) begin
            q1.push_back(wr_data[31:16]); w1 = 1;
        end else begin
            if (l1 >= 1) q1.push_back(wr_data[15:0]);
            if (l1 == 2) q1.push_back(wr_data[31:16]);
        end
        m_ovr = (m_ovr & ~flag_clr) | so;
        m_err = (m_err & ~flag_clr) | se;
    endtask

    task automatic cyc(input bit we, input bit wch, input logic [1:0] strb,
                       input logic [31:0] d, input logic [1:0] rdy, input logic [1:0] clr);
        @(negedge clk);
        check_outputs();
        ch_en = nx_en; mode_ch0 = nx_m0; mode_ch1 = nx_m1;
        wr_en = we; wr_ch = wch; wr_strb = strb; wr_data = d;
        smp_ready = rdy; flag_clr = clr;
        model_step();
    endtask

    task automatic idle(input int n, input logic [1:0] rdy);
        for (int i = 0; i < n; i++) cyc(0, 0, 2'b00, 32'h0, rdy, 2'b00);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R1 watchdog act=expired exp=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        tag = "R1 reset";
        idle(2, 2'b11);

        tag = "R2 standard";
        nx_en = 2'b11; nx_m0 = 2'b00; nx_m1 = 2'b00;
        idle(1, 2'b00);
        cyc(1, 0, 2'b01, 32'hBEEF_1234, 2'b00, 2'b00);
        tag = "R11 hold";
        idle(3, 2'b00);
        tag = "R2 consume";
        idle(2, 2'b01);

        tag = "R10 reserved";
        nx_m1 = 2'b11;
        idle(1, 2'b00);
        cyc(1, 1, 2'b01, 32'h5555_A1A1, 2'b00, 2'b00);
        cyc(0, 0, 2'b00, 32'h0, 2'b10, 2'b00);
        cyc(1, 1, 2'b11, 32'h0000_0001, 2'b00, 2'b00);
        idle(2, 2'b00);

        tag = "R3 interleave";
        nx_m0 = 2'b01; nx_m1 = 2'b00;
        idle(1, 2'b00);
        cyc(1, 0, 2'b11, 32'hCAFE_0F0F, 2'b00, 2'b11);
        idle(2, 2'b00);
        cyc(0, 0, 2'b00, 32'h0, 2'b01, 2'b00);
        tag = "R8 overrun";
        cyc(1, 0, 2'b11, 32'h1111_2222, 2'b00, 2'b00);
        tag = "R3 second";
        idle(3, 2'b01);

        tag = "R4 dual";
        nx_m0 = 2'b10;
        idle(1, 2'b00);
        cyc(1, 0, 2'b11, 32'hD00D_C0DE, 2'b10, 2'b11);
        idle(2, 2'b10);
        cyc(0, 0, 2'b00, 32'h0, 2'b01, 2'b00);
        tag = "R8 dual pending";
        cyc(1, 0, 2'b11, 32'h7777_8888, 2'b00, 2'b00);
        tag = "R4 forward";
        idle(3, 2'b11);

        tag = "R5 protect";
        cyc(1, 1, 2'b01, 32'h0000_0042, 2'b11, 2'b11);
        nx_m0 = 2'b00; nx_m1 = 2'b10;
        idle(1, 2'b11);
        cyc(1, 1, 2'b11, 32'h9999_0042, 2'b11, 2'b00);
        idle(2, 2'b11);

        tag = "R6 strobe";
        nx_m1 = 2'b00;
        cyc(1, 0, 2'b11, 32'h1234_5678, 2'b11, 2'b11);
        cyc(1, 0, 2'b10, 32'h1234_5678, 2'b11, 2'b00);
        idle(2, 2'b11);

        tag = "R9 clear vs set";
        cyc(1, 0, 2'b00, 32'h0, 2'b11, 2'b01);
        idle(2, 2'b11);
        cyc(0, 0, 2'b00, 32'h0, 2'b11, 2'b11);
        idle(2, 2'b11);

        tag = "R7 disabled";
        nx_en = 2'b10;
        idle(1, 2'b11);
        cyc(1, 0, 2'b11, 32'hAAAA_BBBB, 2'b11, 2'b00);
        nx_en = 2'b11;
        idle(3, 2'b11);
        nx_m0 = 2'b01;
        idle(1, 2'b00);
        cyc(1, 0, 2'b11, 32'h4444_3333, 2'b00, 2'b00);
        idle(1, 2'b00);
        nx_en = 2'b10;
        idle(3, 2'b11);
        tag = "R7 flush forward wait";
        nx_en = 2'b11; nx_m0 = 2'b10;
        idle(1, 2'b00);
        cyc(1, 0, 2'b11, 32'hF00D_BEAD, 2'b00, 2'b00);
        idle(1, 2'b00);
        nx_en = 2'b10;
        idle(3, 2'b00);
        nx_en = 2'b11;
        idle(3, 2'b11);

        tag = "R12 random R2/R3/R4/R8/R11";
        for (int i = 0; i < 6000; i++) begin
            bit we, wch;
            logic [1:0] st, rdy, clr;
            if ($urandom_range(0, 63) == 0) nx_en = 2'($urandom);
            if ($urandom_range(0, 15) == 0) nx_en = 2'b11;
            if ($urandom_range(0, 47) == 0) nx_m0 = 2'($urandom);
            if ($urandom_range(0, 47) == 0) nx_m1 = 2'($urandom);
            we  = $urandom_range(0, 2) == 0;
            wch = 1'($urandom);
            st  = ($urandom_range(0, 3) == 0) ? 2'($urandom)
                  : (((wch ? nx_m1 : nx_m0) == 2'b01 || (wch ? nx_m1 : nx_m0) == 2'b10) ? 2'b11 : 2'b01);
            rdy = {$urandom_range(0, 9) < 7, $urandom_range(0, 9) < 7};
            clr = ($urandom_range(0, 31) == 0) ? 2'($urandom) : 2'b00;
            cyc(we, wch, st, $urandom, rdy, clr);
        end
        idle(4, 2'b11);
        finish_run();
    end

endmodule